// File: doc/BRIEF.md
# PCIe Configuration Access Translator

This block converts host configuration accesses made through a flat, memory-mapped window into PCIe-style configuration requests. The host places a 28-bit window address on the request port. The block splits that address into bus, device, function and register fields. Depending on the bus number, it takes one of two paths. It can answer from its own small local register space, which stands for the root port's own function on bus 0. Otherwise it programs its single outbound region with a repacked target address and a request type, then raises one configuration request toward the link side.

The outbound region is kept in registers that software can read through the local space. These registers hold the repacked target, the request type, an enable bit, a completion flag and a timeout flag. A viewport register at a fixed local offset returns all-ones, which tells software the block uses the unrolled region layout. Only one access is in flight at a time. The host holds its request and waits for a one-cycle `host_ready` pulse, which carries read data.

Top module: `cfg_xlate`

## Requirements
- R1: The window address is read as bus = addr[27:20], device = addr[19:15], function = addr[14:12] and register = addr[11:0]. The outbound target is bus in [31:24], device in [23:19], function in [18:16], zeros in [15:12] and the register in [11:0].
- R2: A request to bus 1 goes out with `cfg_req_type` = 0 (Type 0). A request to bus 2 or above goes out with `cfg_req_type` = 1 (Type 1).
- R3: Bus 0, device 0, function 0 is served locally and never raises `cfg_req_valid`. `host_ready` pulses two cycles after acceptance. Offset 0x000 returns the read-only identity value ROOT_ID, and writes to it have no effect. Offsets 0x100 up to 0x100 + 4*SCRATCH_DEPTH - 4 are read/write scratch words. Any other unlisted offset reads 0.
- R4: On bus 0, any access with a non-zero device or function raises no outbound request. A read returns 0xFFFFFFFF and a write changes nothing.
- R5: The viewport register at local offset 0x900 reads 0xFFFFFFFF when UNROLL = 1 (the default).
- R6: Each outbound access first loads the region with three values: the repacked target (offset 0x918), the type (offset 0x904 bit 0) and enable = 1 (offset 0x908 bit 31). A software write to 0x908 sets enable from bit 31. A write to 0x918 sets the target. All region registers are 0 after reset.
- R7: A completion that arrives while a request is outstanding ends the access. `host_ready` pulses on the cycle after the completion. A read returns the completion data, and the done flag (0x908 bit 0) becomes 1.
- R8: If no completion arrives within TIMEOUT cycles of issue, the request is withdrawn. A read returns 0xFFFFFFFF, the timeout flag (0x908 bit 1) becomes 1 and done stays 0.
- R9: Only one request is outstanding at a time. `host_ready` is a one-cycle pulse. While `cfg_req_valid` is high, its address and type stay stable, and the request is issued two cycles after acceptance.
- R10: Each new request re-aims the region to its own target. A value that software wrote into the target register is replaced by the next request's target.
- R11: An outbound write carries `cfg_req_write` = 1 and the host write data on `cfg_req_wdata`. A write returns 0 on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present, held until `host_ready` |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 28 | Flat configuration window address |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle pulse ending the access |
| host_rdata | output | 32 | Read data, valid with `host_ready` |
| cfg_req_valid | output | 1 | Outbound configuration request present |
| cfg_req_type | output | 1 | 0 = Type 0, 1 = Type 1 |
| cfg_req_write | output | 1 | Outbound request is a write |
| cfg_req_addr | output | 32 | Repacked target address |
| cfg_req_wdata | output | 32 | Outbound write data |
| cfg_cpl_valid | input | 1 | Completion for the outstanding request |
| cfg_cpl_data | input | 32 | Completion data |

## Verification
The hardest case to reach from the ports is the timeout path. It needs an outbound request that the link side never answers, followed by a region register read that shows the timeout flag instead of the done flag. The bench's downstream responder takes a per-access latency, and a negative latency makes it stay silent. The bench then counts the exact number of cycles until `host_ready` and reads the control register back through the local space. A software-written target is also overwritten by a later request. To check this, the bench writes the target register, reads it back, issues an outbound access and reads the target again.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  localparam int ADDR_W = 28;
  localparam int DATA_W = 32;

  // local register offsets (root function)
  localparam logic [11:0] OFF_ID       = 12'h000;
  localparam logic [11:0] OFF_SCR_BASE = 12'h100;
  localparam logic [11:0] OFF_VIEWPORT = 12'h900;
  localparam logic [11:0] OFF_RG_TYPE  = 12'h904;
  localparam logic [11:0] OFF_RG_CTRL  = 12'h908;
  localparam logic [11:0] OFF_RG_TGT   = 12'h918;

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
  } cfg_loc_t;

  typedef enum logic [1:0] {
    TOP_IDLE  = 2'd0,
    TOP_LOCAL = 2'd1,
    TOP_OUT   = 2'd2
  } top_st_t;

  typedef enum logic [1:0] {
    OB_IDLE = 2'd0,
    OB_AIM  = 2'd1,
    OB_WAIT = 2'd2
  } ob_st_t;

  function automatic logic [31:0] repack(input cfg_loc_t l);
    return {l.bus, l.dev, l.fn, 4'b0000, l.off};
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [11:0]       off,
  output logic              root_bus,
  output logic              root_fn,
  output logic              type1,
  output logic [31:0]       target
);

  cfg_loc_t loc;

  always_comb begin
    loc      = cfg_loc_t'(addr);
    off      = loc.off;
    root_bus = (loc.bus == 8'd0);
    root_fn  = (loc.dev == 5'd0) && (loc.fn == 3'd0);
    type1    = (loc.bus > 8'd1);
    target   = repack(loc);
  end

endmodule

// File: rtl/cfg_local_regs.sv
module cfg_local_regs
  import cfg_xlate_pkg::*;
#(
  parameter int          SCRATCH_DEPTH = 16,
  parameter bit          UNROLL        = 1'b1,
  parameter logic [31:0] ROOT_ID       = 32'h1E5A_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic        wr,
  input  logic [11:0] off,
  input  logic [31:0] wdata,
  input  logic        rg_type1,
  input  logic        rg_en,
  input  logic        rg_done,
  input  logic        rg_tmo,
  input  logic [31:0] rg_tgt,
  output logic        sw_tgt_we,
  output logic        sw_ctrl_we,
  output logic [31:0] rdata
);

  localparam int          IW   = (SCRATCH_DEPTH > 1) ? $clog2(SCRATCH_DEPTH) : 1;
  localparam logic [12:0] SPAN = 13'(4 * SCRATCH_DEPTH);

  logic [31:0] mem [SCRATCH_DEPTH];
  logic [31:0] mem_q;
  logic [31:0] reg_q;
  logic        sel_mem;
  logic [11:0] diff;
  logic        in_scr;
  logic [IW-1:0] idx;
  logic [31:0] reg_mux;

  always_comb begin
    diff   = off - OFF_SCR_BASE;
    in_scr = (off >= OFF_SCR_BASE) && ({1'b0, diff} < SPAN);
    idx    = diff[IW+1:2];
  end

  assign sw_tgt_we  = acc && wr && (off == OFF_RG_TGT);
  assign sw_ctrl_we = acc && wr && (off == OFF_RG_CTRL);

  // scratch words: plain synchronous RAM
  always_ff @(posedge clk) begin
    if (acc && wr && in_scr) mem[idx] <= wdata;
    mem_q <= mem[idx];
  end

  always_comb begin
    unique case (off)
      OFF_ID:       reg_mux = ROOT_ID;
      OFF_VIEWPORT: reg_mux = UNROLL ? 32'hFFFF_FFFF : 32'h0000_0000;
      OFF_RG_TYPE:  reg_mux = {31'b0, rg_type1};
      OFF_RG_CTRL:  reg_mux = {rg_en, 29'b0, rg_tmo, rg_done};
      OFF_RG_TGT:   reg_mux = rg_tgt;
      default:      reg_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      sel_mem <= 1'b0;
    end else if (acc) begin
      reg_q   <= reg_mux;
      sel_mem <= in_scr;
    end
  end

  assign rdata = sel_mem ? mem_q : reg_q;

endmodule

// File: rtl/cfg_outbound.sv
module cfg_outbound
  import cfg_xlate_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aim,
  input  logic        aim_type1,
  input  logic [31:0] aim_tgt,
  input  logic        aim_write,
  input  logic [31:0] aim_wdata,
  input  logic        sw_tgt_we,
  input  logic        sw_ctrl_we,
  input  logic [31:0] sw_wdata,
  input  logic        cpl_valid,
  input  logic [31:0] cpl_data,
  output logic        req_valid,
  output logic        req_write,
  output logic [31:0] req_wdata,
  output logic        rg_type1,
  output logic        rg_en,
  output logic        rg_done,
  output logic        rg_tmo,
  output logic [31:0] rg_tgt,
  output logic        fin,
  output logic [31:0] fin_data
);

  localparam int CW = $clog2(TIMEOUT + 1);

  ob_st_t      st;
  logic [CW-1:0] cnt;
  logic        expired;

  assign expired  = (cnt == CW'(TIMEOUT - 1));
  assign fin      = (st == OB_WAIT) && (cpl_valid || expired);
  assign fin_data = cpl_valid ? cpl_data : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= OB_IDLE;
      cnt       <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_wdata <= '0;
      rg_type1  <= 1'b0;
      rg_en     <= 1'b0;
      rg_done   <= 1'b0;
      rg_tmo    <= 1'b0;
      rg_tgt    <= '0;
    end else begin
      unique case (st)
        OB_IDLE: begin
          if (aim) begin
            rg_tgt    <= aim_tgt;
            rg_type1  <= aim_type1;
            rg_en     <= 1'b1;
            rg_done   <= 1'b0;
            rg_tmo    <= 1'b0;
            req_write <= aim_write;
            req_wdata <= aim_wdata;
            st        <= OB_AIM;
          end else begin
            if (sw_tgt_we)  rg_tgt <= sw_wdata;
            if (sw_ctrl_we) rg_en  <= sw_wdata[31];
          end
        end
        OB_AIM: begin
          // issue only once the region reads back as enabled
          if (rg_en) begin
            req_valid <= 1'b1;
            cnt       <= '0;
            st        <= OB_WAIT;
          end
        end
        OB_WAIT: begin
          if (cpl_valid) begin
            req_valid <= 1'b0;
            rg_done   <= 1'b1;
            st        <= OB_IDLE;
          end else if (expired) begin
            req_valid <= 1'b0;
            rg_tmo    <= 1'b1;
            st        <= OB_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= OB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int          TIMEOUT       = 64,
  parameter int          SCRATCH_DEPTH = 16,
  parameter bit          UNROLL        = 1'b1,
  parameter logic [31:0] ROOT_ID       = 32'h1E5A_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic [27:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic        host_ready,
  output logic [31:0] host_rdata,
  output logic        cfg_req_valid,
  output logic        cfg_req_type,
  output logic        cfg_req_write,
  output logic [31:0] cfg_req_addr,
  output logic [31:0] cfg_req_wdata,
  input  logic        cfg_cpl_valid,
  input  logic [31:0] cfg_cpl_data
);

  top_st_t     st;
  logic [11:0] d_off;
  logic        d_root_bus, d_root_fn, d_type1;
  logic [31:0] d_tgt;
  logic        accept, loc_acc, aim;
  logic        was_fn, was_wr;
  logic        sw_tgt_we, sw_ctrl_we;
  logic        rg_type1, rg_en, rg_done, rg_tmo;
  logic [31:0] rg_tgt, loc_rdata;
  logic        fin;
  logic [31:0] fin_data;

  cfg_addr_decode u_dec (
    .addr     (host_addr),
    .off      (d_off),
    .root_bus (d_root_bus),
    .root_fn  (d_root_fn),
    .type1    (d_type1),
    .target   (d_tgt)
  );

  assign accept  = (st == TOP_IDLE) && host_valid && !host_ready;
  assign loc_acc = accept && d_root_bus && d_root_fn;
  assign aim     = accept && !d_root_bus;

  cfg_local_regs #(
    .SCRATCH_DEPTH (SCRATCH_DEPTH),
    .UNROLL        (UNROLL),
    .ROOT_ID       (ROOT_ID)
  ) u_loc (
    .clk        (clk),
    .rst        (rst),
    .acc        (loc_acc),
    .wr         (host_write),
    .off        (d_off),
    .wdata      (host_wdata),
    .rg_type1   (rg_type1),
    .rg_en      (rg_en),
    .rg_done    (rg_done),
    .rg_tmo     (rg_tmo),
    .rg_tgt     (rg_tgt),
    .sw_tgt_we  (sw_tgt_we),
    .sw_ctrl_we (sw_ctrl_we),
    .rdata      (loc_rdata)
  );

  cfg_outbound #(
    .TIMEOUT (TIMEOUT)
  ) u_ob (
    .clk        (clk),
    .rst        (rst),
    .aim        (aim),
    .aim_type1  (d_type1),
    .aim_tgt    (d_tgt),
    .aim_write  (host_write),
    .aim_wdata  (host_wdata),
    .sw_tgt_we  (sw_tgt_we),
    .sw_ctrl_we (sw_ctrl_we),
    .sw_wdata   (host_wdata),
    .cpl_valid  (cfg_cpl_valid),
    .cpl_data   (cfg_cpl_data),
    .req_valid  (cfg_req_valid),
    .req_write  (cfg_req_write),
    .req_wdata  (cfg_req_wdata),
    .rg_type1   (rg_type1),
    .rg_en      (rg_en),
    .rg_done    (rg_done),
    .rg_tmo     (rg_tmo),
    .rg_tgt     (rg_tgt),
    .fin        (fin),
    .fin_data   (fin_data)
  );

  assign cfg_req_addr = rg_tgt;
  assign cfg_req_type = rg_type1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TOP_IDLE;
      host_ready <= 1'b0;
      host_rdata <= '0;
      was_fn     <= 1'b0;
      was_wr     <= 1'b0;
    end else begin
      host_ready <= 1'b0;
      unique case (st)
        TOP_IDLE: begin
          if (accept) begin
            was_fn <= d_root_fn;
            was_wr <= host_write;
            st     <= d_root_bus ? TOP_LOCAL : TOP_OUT;
          end
        end
        TOP_LOCAL: begin
          host_ready <= 1'b1;
          if (was_wr)      host_rdata <= 32'h0;
          else if (was_fn) host_rdata <= loc_rdata;
          else             host_rdata <= 32'hFFFF_FFFF;
          st <= TOP_IDLE;
        end
        TOP_OUT: begin
          if (fin) begin
            host_ready <= 1'b1;
            host_rdata <= was_wr ? 32'h0 : fin_data;
            st         <= TOP_IDLE;
          end
        end
        default: st <= TOP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic [27:0] host_addr,
  input logic        host_ready,
  input logic        cfg_req_valid,
  input logic        cfg_req_type,
  input logic [31:0] cfg_req_addr,
  input logic        cfg_cpl_valid
);

  // R1
  addr_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> (cfg_req_addr[15:12] == 4'h0));

  // R2
  type_by_bus_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> (cfg_req_type == (cfg_req_addr[31:24] > 8'd1)));

  // R3
  no_root_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_valid) |-> ($past(host_addr[27:20]) != 8'd0));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid && !cfg_cpl_valid) |=> ($stable(cfg_req_addr) && $stable(cfg_req_type)));

  // R7
  done_retires_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> !cfg_req_valid);

endmodule

bind cfg_xlate cfg_xlate_chk u_chk (.*);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;

  localparam int          TMO     = 64;
  localparam logic [31:0] ROOT_ID = 32'h1E5A_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [27:0] host_addr  = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        cfg_req_valid, cfg_req_type, cfg_req_write;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic        cfg_cpl_valid = 1'b0;
  logic [31:0] cfg_cpl_data  = '0;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  // behavioural model of the root's state
  int unsigned m_scr [int];
  logic [31:0] m_tgt   = '0;
  logic        m_type1 = 1'b0;
  logic        m_en = 1'b0, m_done = 1'b0, m_tmo = 1'b0;

  always #2 clk = ~clk;

  cfg_xlate u_dut (
    .clk (clk), .rst (rst),
    .host_valid (host_valid), .host_write (host_write),
    .host_addr (host_addr), .host_wdata (host_wdata),
    .host_ready (host_ready), .host_rdata (host_rdata),
    .cfg_req_valid (cfg_req_valid), .cfg_req_type (cfg_req_type),
    .cfg_req_write (cfg_req_write), .cfg_req_addr (cfg_req_addr),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_cpl_valid (cfg_cpl_valid), .cfg_cpl_data (cfg_cpl_data)
  );

  function automatic logic [27:0] waddr(int bus, int dev, int fn, int off);
    return {8'(bus), 5'(dev), 3'(fn), 12'(off)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] model_local_read(int off);
    if (off == 'h000) return ROOT_ID;
    if (off >= 'h100 && off < 'h140) return m_scr.exists(off) ? m_scr[off] : 32'h0;
    if (off == 'h900) return 32'hFFFF_FFFF;
    if (off == 'h904) return {31'b0, m_type1};
    if (off == 'h908) return {m_en, 29'b0, m_tmo, m_done};
    if (off == 'h918) return m_tgt;
    return 32'h0;
  endfunction

  // one host access; lat < 0 means the link side never completes
  task automatic access(string tag, bit wr, int bus, int dev, int fn, int off,
                        logic [31:0] wd, int lat, logic [31:0] cpl_d);
    bit          outb = (bus != 0);
    int          rdy_n;
    logic [31:0] exp_rd;
    if (!outb) begin
      rdy_n = 2;
      if (wr) exp_rd = 0;
      else if (dev == 0 && fn == 0) exp_rd = model_local_read(off);
      else exp_rd = 32'hFFFF_FFFF;
    end else begin
      rdy_n = (lat >= 0) ? 3 + lat : 2 + TMO;
      exp_rd = wr ? 32'h0 : ((lat >= 0) ? cpl_d : 32'hFFFF_FFFF);
    end
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = waddr(bus, dev, fn, off); host_wdata = wd;
    for (int n = 1; n <= rdy_n; n++) begin
      @(negedge clk);
      if (cfg_cpl_valid) cfg_cpl_valid = 0;
      if (outb && lat >= 0 && n == 2 + lat) begin
        cfg_cpl_valid = 1; cfg_cpl_data = cpl_d;
      end
      // R9: one request, issued two cycles after acceptance, held until done
      if (cfg_req_valid !== (outb && n >= 2 && n < rdy_n))
        chk({tag, " R9 req_valid"}, {31'b0, cfg_req_valid}, {31'b0, outb && n >= 2 && n < rdy_n});
      if (host_ready !== (n == rdy_n))
        chk({tag, " R9 ready timing"}, {31'b0, host_ready}, {31'b0, n == rdy_n});
      if (outb && n == 2) begin
        chk({tag, " R1 target"}, cfg_req_addr, {8'(bus), 5'(dev), 3'(fn), 4'b0, 12'(off)});
        chk({tag, " R2 type"}, {31'b0, cfg_req_type}, {31'b0, bus >= 2});
        chk({tag, " R11 write flag"}, {31'b0, cfg_req_write}, {31'b0, wr});
        if (wr) chk({tag, " R11 wdata"}, cfg_req_wdata, wd);
      end
    end
    chk({tag, " data"}, host_rdata, exp_rd);
    host_valid = 0;
    if (cfg_cpl_valid) begin
      @(negedge clk);
      cfg_cpl_valid = 0;
    end
    // update model
    if (outb) begin
      m_tgt = {8'(bus), 5'(dev), 3'(fn), 4'b0, 12'(off)};
      m_type1 = (bus >= 2); m_en = 1;
      m_done = (lat >= 0); m_tmo = (lat < 0);
    end else if (wr && dev == 0 && fn == 0) begin
      if (off >= 'h100 && off < 'h140) m_scr[off] = wd;
      if (off == 'h918) m_tgt = wd;
      if (off == 'h908) m_en = wd[31];
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    // reset state (R6, R9)
    chk("R9 reset ready", {31'b0, host_ready}, 32'h0);
    chk("R9 reset req_valid", {31'b0, cfg_req_valid}, 32'h0);
    access("R6 reset ctrl", 0, 0, 0, 0, 'h908, 0, 0, 0);
    access("R6 reset target", 0, 0, 0, 0, 'h918, 0, 0, 0);
    // R3 local space
    access("R3 id", 0, 0, 0, 0, 'h000, 0, 0, 0);
    access("R3 scratch wr", 1, 0, 0, 0, 'h104, 32'hA5A5_0104, 0, 0);
    access("R3 scratch wr2", 1, 0, 0, 0, 'h13C, 32'h0BAD_F00D, 0, 0);
    access("R3 scratch rd", 0, 0, 0, 0, 'h104, 0, 0, 0);
    access("R3 scratch rd2", 0, 0, 0, 0, 'h13C, 0, 0, 0);
    access("R3 id wr", 1, 0, 0, 0, 'h000, 32'h1234_5678, 0, 0);
    access("R3 id ro", 0, 0, 0, 0, 'h000, 0, 0, 0);
    access("R3 unmapped", 0, 0, 0, 0, 'h7F0, 0, 0, 0);
    // R5 viewport
    access("R5 viewport", 0, 0, 0, 0, 'h900, 0, 0, 0);
    // R4 absent root functions
    access("R4 dev3", 0, 0, 3, 0, 'h000, 0, 0, 0);
    access("R4 fn1", 0, 0, 0, 1, 'h104, 0, 0, 0);
    access("R4 wr dev1", 1, 0, 1, 0, 'h104, 32'hFFFF_0000, 0, 0);
    access("R4 scratch kept", 0, 0, 0, 0, 'h104, 0, 0, 0);
    // R1 R2 R7 Type 0 read
    access("R7 bus1 rd", 0, 1, 2, 0, 'h010, 0, 0, 32'h1234_5678);
    access("R6 tgt after aim", 0, 0, 0, 0, 'h918, 0, 0, 0);
    access("R6 type after aim", 0, 0, 0, 0, 'h904, 0, 0, 0);
    access("R7 done flag", 0, 0, 0, 0, 'h908, 0, 0, 0);
    // R2 Type 1, extreme fields
    access("R2 bus5 rd", 0, 5, 31, 7, 'hFFC, 0, 3, 32'hCAFE_0005);
    access("R2 bus255 rd", 0, 255, 0, 0, 'h000, 0, 1, 32'h0000_00FF);
    access("R6 type1", 0, 0, 0, 0, 'h904, 0, 0, 0);
    // R11 outbound write
    access("R11 bus2 wr", 1, 2, 1, 2, 'h040, 32'hDEAD_BEEF, 1, 32'h0);
    // R8 timeout
    access("R8 timeout rd", 0, 3, 4, 5, 'h100, 0, -1, 0);
    access("R8 tmo flag", 0, 0, 0, 0, 'h908, 0, 0, 0);
    access("R8 timeout wr", 1, 7, 0, 0, 'h008, 32'h5555_AAAA, -1, 0);
    // R10 software target then re-aim
    access("R10 sw tgt wr", 1, 0, 0, 0, 'h918, 32'hDEAD_0000, 0, 0);
    access("R10 sw tgt rd", 0, 0, 0, 0, 'h918, 0, 0, 0);
    access("R10 new req", 0, 1, 4, 0, 'h0A0, 0, 2, 32'h0000_4444);
    access("R10 tgt replaced", 0, 0, 0, 0, 'h918, 0, 0, 0);
    // R6 software clears enable
    access("R6 en clear", 1, 0, 0, 0, 'h908, 32'h0, 0, 0);
    access("R6 en readback", 0, 0, 0, 0, 'h908, 0, 0, 0);
    access("R10 reaim after clear", 0, 9, 1, 1, 'h004, 0, 0, 32'h9999_0001);
    access("R6 en set again", 0, 0, 0, 0, 'h908, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule